// File: doc/BRIEF.md
# Modem Status Loopback Delta Tracker

This block owns the modem control register and the modem status register of a 16550-compatible serial port. Software writes the control register through a write strobe and data byte, and reads the status register through a read strobe. The block keeps the four status lines (clear-to-send, data-set-ready, ring indicator, carrier detect) and four sticky change flags next to them.

When the loopback bit of the control register is set, the status lines are copied from control bits. Without loopback they take a fixed idle value in which carrier detect and data-set-ready are asserted. Each control write compares the old and new status lines and raises the matching change flag. The ring flag is different: it fires only when the ring line falls. A read of the status register returns the value that was current before the read edge and then clears all change flags. A single output tells an interrupt encoder that at least one change flag is set.

Top module: `modem_status_tracker`

## Requirements
- R1: A control write stores only bits 4:0 of the data; `mcr_out[7:5]` always reads 0.
- R2: With `mcr_out[4]` (loopback) set, the status lines are `msr_out[4]`=`mcr_out[1]`, `msr_out[5]`=`mcr_out[0]`, `msr_out[6]`=`mcr_out[2]`, `msr_out[7]`=`mcr_out[3]`.
- R3: With loopback clear, `msr_out[7:4]` is 4'b1010 (bit 7 and bit 5 set, bits 6 and 4 clear).
- R4: A control write that changes `msr_out[4]`, `msr_out[5]` or `msr_out[7]` sets `msr_out[0]`, `msr_out[1]` or `msr_out[3]` respectively.
- R5: A control write sets `msr_out[2]` only when the ring line `msr_out[6]` goes from 1 to 0; a 0-to-1 change leaves it alone.
- R6: Change flags are sticky: a control write never clears one, and without a read they keep their value.
- R7: A read strobe leaves `msr_out` unchanged in the read cycle and clears `msr_out[3:0]` at the read edge.
- R8: When a write and a read strike the same edge, old flags are cleared and the flags raised by the write survive.
- R9: After reset `mcr_out` is 8'h00 and `msr_out` is 8'hA0.
- R10: `delta_any` is high exactly when any of `msr_out[3:0]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcr_wr_en | input | 1 | Control register write strobe |
| mcr_wr_data | input | 8 | Control register write data |
| msr_rd_en | input | 1 | Status register read strobe (clears flags) |
| msr_out | output | 8 | Status register value |
| mcr_out | output | 8 | Control register value |
| delta_any | output | 1 | Some change flag is set |

## Verification
A wrong stored control value shows on `mcr_out` and, in loopback, on the status nibble in the cycle after the write. A change flag that was wrongly set, lost, or not cleared shows on `msr_out[3:0]` and `delta_any` one edge after the write or read that caused it, so each write and read is followed by a compare against a bench model before the next access. Falling and rising ring transitions and same-edge read/write are driven separately, because those are the paths where a wrong flag would otherwise stay hidden.

// File: rtl/modem_stat_pkg.sv
package modem_stat_pkg;
  localparam int REG_W    = 8;
  localparam int CTRL_KEEP = 5;
  localparam int LINE_N   = 4;

  // control bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_AUX1 = 2;
  localparam int C_AUX2 = 3;
  localparam int C_LOOP = 4;

  // line index inside the status nibble (status bit = LINE_N + index)
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  localparam logic [LINE_N-1:0] IDLE_LINES = 4'b1010;

  typedef logic [LINE_N-1:0] line_t;
endpackage

// File: rtl/mst_ctrl_reg.sv
module mst_ctrl_reg
  import modem_stat_pkg::*;
#(
  parameter int W    = REG_W,
  parameter int KEEP = CTRL_KEEP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl_q
);
  logic [KEEP-1:0] kept_d, kept_q;

  always_comb begin
    kept_d = kept_q;
    if (wr_en) kept_d = wr_data[KEEP-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     kept_q <= '0;
    else if (wr_en) kept_q <= kept_d;
  end

  assign ctrl_q = {{(W-KEEP){1'b0}}, kept_q};
endmodule

// File: rtl/mst_line_map.sv
module mst_line_map
  import modem_stat_pkg::*;
#(
  parameter int KEEP = CTRL_KEEP
) (
  input  logic [KEEP-1:0] ctrl,
  output line_t           lines
);
  always_comb begin
    if (ctrl[C_LOOP]) begin
      lines        = '0;
      lines[L_CTS] = ctrl[C_RTS];
      lines[L_DSR] = ctrl[C_DTR];
      lines[L_RI]  = ctrl[C_AUX1];
      lines[L_DCD] = ctrl[C_AUX2];
    end else begin
      lines = IDLE_LINES;
    end
  end
endmodule

// File: rtl/mst_delta_track.sv
module mst_delta_track
  import modem_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_en,
  input  line_t new_lines,
  input  logic  clr_en,
  output line_t lines_q,
  output line_t delta_q
);
  line_t lines_d, delta_d, raise;

  // per-line change detection; ring uses a falling-edge rule
  for (genvar i = 0; i < LINE_N; i++) begin : g_chg
    if (i == L_RI) begin : g_fall
      assign raise[i] = lines_q[i] & ~new_lines[i];
    end else begin : g_any
      assign raise[i] = lines_q[i] ^ new_lines[i];
    end
  end

  always_comb begin
    lines_d = upd_en ? new_lines : lines_q;
    delta_d = (clr_en ? '0 : delta_q) | (upd_en ? raise : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= IDLE_LINES;
      delta_q <= '0;
    end else if (upd_en || clr_en) begin
      lines_q <= lines_d;
      delta_q <= delta_d;
    end
  end
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
  import modem_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mcr_wr_en,
  input  logic [REG_W-1:0] mcr_wr_data,
  input  logic             msr_rd_en,
  output logic [REG_W-1:0] msr_out,
  output logic [REG_W-1:0] mcr_out,
  output logic             delta_any
);
  line_t next_lines, lines_q, delta_q;
  logic [REG_W-1:0] ctrl_q;

  mst_ctrl_reg #(.W(REG_W), .KEEP(CTRL_KEEP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(mcr_wr_en),
    .wr_data(mcr_wr_data), .ctrl_q(ctrl_q)
  );

  // status lines are computed from the data being written
  mst_line_map #(.KEEP(CTRL_KEEP)) u_map (
    .ctrl(mcr_wr_data[CTRL_KEEP-1:0]), .lines(next_lines)
  );

  mst_delta_track u_delta (
    .clk(clk), .rst_n(rst_n), .upd_en(mcr_wr_en), .new_lines(next_lines),
    .clr_en(msr_rd_en), .lines_q(lines_q), .delta_q(delta_q)
  );

  assign mcr_out   = ctrl_q;
  assign msr_out   = {lines_q, delta_q};
  assign delta_any = |delta_q;
endmodule

// File: rtl/mst_checker.sv
module mst_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mcr_wr_en,
  input logic       msr_rd_en,
  input logic [7:0] msr_out,
  input logic [7:0] mcr_out,
  input logic       delta_any
);
  AST_CTRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_out[7:5] == 3'b000); // R1

  AST_LOOP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_out[4] |-> msr_out[7:4] == {mcr_out[3], mcr_out[2], mcr_out[0], mcr_out[1]}); // R2

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !mcr_out[4] |-> msr_out[7:4] == 4'b1010); // R3

  AST_RING_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_rd_en && !msr_out[2]) |=> msr_out[2] == ($past(msr_out[6]) && !msr_out[6])); // R5

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !msr_rd_en |=> (msr_out[3:0] & $past(msr_out[3:0])) == $past(msr_out[3:0])); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd_en && !mcr_wr_en) |=> msr_out[3:0] == 4'b0000); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_rd_en && !mcr_wr_en) |=> $stable(msr_out) && $stable(mcr_out)); // R6

  AST_ANY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    delta_any == (msr_out[3:0] != 4'b0000)); // R10
endmodule

bind modem_status_tracker mst_checker u_mst_checker (
  .clk(clk), .rst_n(rst_n), .mcr_wr_en(mcr_wr_en), .msr_rd_en(msr_rd_en),
  .msr_out(msr_out), .mcr_out(mcr_out), .delta_any(delta_any)
);

// File: tb/test_modem_status_tracker.sv
module test_modem_status_tracker;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mcr_wr_en = 1'b0;
  logic [7:0] mcr_wr_data = 8'h00;
  logic       msr_rd_en = 1'b0;
  logic [7:0] msr_out, mcr_out;
  logic       delta_any;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] m_mcr, m_msr;

  modem_status_tracker i_modem_status_tracker (
    .clk(clk), .rst_n(rst_n), .mcr_wr_en(mcr_wr_en), .mcr_wr_data(mcr_wr_data),
    .msr_rd_en(msr_rd_en), .msr_out(msr_out), .mcr_out(mcr_out), .delta_any(delta_any)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] lines_of(input logic [7:0] c);
    if (c[4]) return {c[3], c[2], c[0], c[1]};
    return 4'b1010;
  endfunction

  function automatic logic [7:0] after_write(input logic [7:0] old, input logic [7:0] c, input logic clr);
    logic [3:0] nl, d;
    nl = lines_of(c);
    d  = clr ? 4'b0 : old[3:0];
    if (old[4] != nl[0]) d[0] = 1'b1;
    if (old[5] != nl[1]) d[1] = 1'b1;
    if (old[7] != nl[3]) d[3] = 1'b1;
    if (old[6] && !nl[2]) d[2] = 1'b1;
    return {nl, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, {24'h0, msr_out}, {24'h0, m_msr});
    check(req, {24'h0, mcr_out}, {24'h0, m_mcr});
    check("R10", {31'h0, delta_any}, {31'h0, m_msr[3:0] != 4'b0});
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    mcr_wr_en = 1'b1; mcr_wr_data = v;
    @(negedge clk);
    mcr_wr_en = 1'b0;
    m_msr = after_write(m_msr, v, 1'b0);
    m_mcr = {3'b000, v[4:0]};
  endtask

  task automatic do_read(input string req);
    @(negedge clk);
    msr_rd_en = 1'b1;
    check(req, {24'h0, msr_out}, {24'h0, m_msr});
    @(negedge clk);
    msr_rd_en = 1'b0;
    m_msr[3:0] = 4'b0;
  endtask

  task automatic t_reset;
    m_mcr = 8'h00; m_msr = 8'hA0;
    check_all("R9");
  endtask

  task automatic t_mask;
    do_write(8'hE0);
    check_all("R1");
    do_read("R1");
  endtask

  task automatic t_loop_map;
    do_write(8'h11); check_all("R2");
    do_read("R2");
    do_write(8'h12); check_all("R2");
    do_write(8'h1C); check_all("R2");
    do_read("R2");
    do_write(8'h1F); check_all("R2");
    do_read("R2");
  endtask

  task automatic t_idle;
    do_write(8'h0F); check_all("R3");
    check("R3", {28'h0, msr_out[7:4]}, 32'hA);
    do_read("R3");
  endtask

  task automatic t_delta_set;
    do_write(8'h10); check_all("R4");
    check("R4", {28'h0, msr_out[3:0]}, 32'hA);
    do_read("R4");
    do_write(8'h12); check_all("R4");
    check("R4", {28'h0, msr_out[3:0]}, 32'h1);
    do_read("R4");
  endtask

  task automatic t_ring;
    do_write(8'h14); check_all("R5");
    check("R5", {31'h0, msr_out[2]}, 32'h0);
    do_read("R5");
    do_write(8'h10); check_all("R5");
    check("R5", {31'h0, msr_out[2]}, 32'h1);
    do_read("R5");
  endtask

  task automatic t_sticky;
    do_write(8'h19); check_all("R6");
    do_write(8'h19); check_all("R6");
    repeat (3) @(negedge clk);
    check_all("R6");
    do_read("R7");
    check_all("R7");
    check("R7", {28'h0, msr_out[3:0]}, 32'h0);
  endtask

  task automatic t_same_edge;
    do_write(8'h11);
    @(negedge clk);
    mcr_wr_en = 1'b1; mcr_wr_data = 8'h13; msr_rd_en = 1'b1;
    check("R8", {24'h0, msr_out}, {24'h0, m_msr});
    @(negedge clk);
    mcr_wr_en = 1'b0; msr_rd_en = 1'b0;
    m_msr = after_write(m_msr, 8'h13, 1'b1);
    m_mcr = 8'h13;
    check_all("R8");
    check("R8", {28'h0, msr_out[3:0]}, 32'h1);
    do_read("R8");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_mask;
        t_loop_map;
        t_idle;
        t_delta_set;
        t_ring;
        t_sticky;
        t_same_edge;
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule